// File: doc/BRIEF.md
# Two-stage countdown watchdog

This is a watchdog peripheral on a small register bus. A counter of `CNT_W` bits counts down by one on each `tick` pulse from an external prescaler. Software keeps the system alive by writing a kick command, which reloads the counter from a programmable initial value. A halt bit freezes the counter.

When the counter reaches zero, the next tick is an expiry, and the counter then reloads. The first expiry raises a first-timeout flag. If another expiry occurs while that flag is still set, the block raises a second-timeout flag and sends a one-cycle reset request, unless the no-reboot bit is set. If software clears the first-timeout flag between expiries, the two-stage sequence starts again. All status flags are cleared by writing a one to them.

Register word addresses:
- 0: kick / count
- 1: initial value
- 2: status A
- 3: status B
- 4: control

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, control reads 0x0801 (halt in bit 11, no-reboot in bit 0). The initial value and the count both read 4, status A reads 0, status B reads 0x0004 (boot flag in bit 2), and `rst_req` is low.
- R2: A write to address 1 stores bits [15:10] as plain read-back storage. Bits [9:0] are taken only if they are 4 or more; a value of 0 to 3 leaves the previous initial value in place.
- R3: While the halt bit is 1, ticks leave the count unchanged.
- R4: Writing exactly 0x0001 to address 0 loads the count with the initial value. Writing any other value to address 0 has no effect.
- R5: While running, each tick lowers the count by one, and address 0 returns the count in bits [9:0].
- R6: A tick at count 0 is an expiry, and the count reloads to the initial value. After a kick, the first expiry comes on tick number init+1.
- R7: The first expiry sets bit 3 of status A. Writing 1 to that bit clears it; writing 0 leaves it set.
- R8: An expiry while status A bit 3 is set sets bit 1 of status B. It also pulses `rst_req` when no-reboot is 0.
- R9: With no-reboot set, `rst_req` stays low, but both timeout flags still set.
- R10: The boot flag (status B bit 2) clears when 1 is written to it.
- R11: `rst_req` is high for one clock only. It does not pulse again while status B bit 1 stays set.
- R12: If status A bit 3 is cleared before the next expiry, that expiry sets only the first-timeout flag and gives no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from prescaler |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 16 | Read data for `addr` |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default 10-bit counter. It then programs small initial values, 4 through 12, so that every count from the initial value down to zero can be read back, and it checks where both expiries fall. Setting no-reboot on alternate values covers both the gated and the ungated reset request. The values 0 to 3 are each tried as initial values to cover the rejection path.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int CNT_W    = 10,
  parameter int DW       = 16,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  localparam int SPW = DW - CNT_W;

  logic [CNT_W-1:0] cnt, init_q;
  logic [SPW-1:0]   spare;
  logic             halt, noreb, sto1, sto2, boot;

  wire wr_kick = we && addr == 3'd0 && wdata == DW'(1);
  wire wr_init = we && addr == 3'd1;
  wire wr_s1   = we && addr == 3'd2;
  wire wr_s2   = we && addr == 3'd3;
  wire wr_ctl  = we && addr == 3'd4;
  wire run     = tick && !halt && !wr_kick;
  wire expire  = run && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CNT_W'(RST_INIT);
      init_q  <= CNT_W'(RST_INIT);
      spare   <= '0;
      halt    <= 1'b1;
      noreb   <= 1'b1;
      sto1    <= 1'b0;
      sto2    <= 1'b0;
      boot    <= 1'b1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire && sto1 && !sto2 && !noreb;
      if (wr_kick)     cnt <= init_q;
      else if (expire) cnt <= init_q;
      else if (run)    cnt <= cnt - 1'b1;
      if (wr_init) begin
        spare <= wdata[DW-1:CNT_W];
        if (wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT)) init_q <= wdata[CNT_W-1:0];
      end
      if (wr_ctl) begin
        halt  <= wdata[11];
        noreb <= wdata[0];
      end
      sto1 <= expire || (sto1 && !(wr_s1 && wdata[3]));
      sto2 <= (expire && sto1) || (sto2 && !(wr_s2 && wdata[1]));
      boot <= boot && !(wr_s2 && wdata[2]);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[CNT_W-1:0] = cnt;
      3'd1: rdata = {spare, init_q};
      3'd2: rdata[3] = sto1;
      3'd3: begin rdata[1] = sto2; rdata[2] = boot; end
      3'd4: begin rdata[11] = halt; rdata[0] = noreb; end
      default: rdata = '0;
    endcase
  end

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R9
  no_reboot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(noreb));
  // R8
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sto2 && sto1);
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !wr_kick |=> $stable(cnt));
  // R2
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(MIN_INIT));
  // R6
  expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(init_q));
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  logic clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic rst_req;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  wdog_two_stage i_wdog_two_stage (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata), .rst_req(rst_req));

  always #4 clk = ~clk;
  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd4, d); chk("R1 ctrl", d, 16'h0801);
    rd(3'd1, d); chk("R1 init", d, 16'd4);
    rd(3'd0, d); chk("R1 count", d, 16'd4);
    rd(3'd2, d); chk("R1 statA", d, 16'h0000);
    rd(3'd3, d); chk("R1 statB", d, 16'h0004);
    chk("R1 rst_req", {15'd0, rst_req}, 16'd0);
    // R10 boot flag W1C
    wr(3'd3, 16'h0000); rd(3'd3, d); chk("R10 keep", d, 16'h0004);
    wr(3'd3, 16'h0004); rd(3'd3, d); chk("R10 clear", d, 16'h0000);
    // R2 rejection of small values and spare bits
    wr(3'd1, 16'd7);
    for (int v = 0; v < 4; v++) begin
      wr(3'd1, 16'(v)); rd(3'd1, d); chk("R2 reject", d, 16'd7);
    end
    wr(3'hA, 16'd0);
    wr(3'd1, 16'hA809); rd(3'd1, d); chk("R2 spare", d, 16'hA809);
    wr(3'd1, 16'hFC02); rd(3'd1, d); chk("R2 spare keep low", d, 16'hFC09);
    wr(3'd1, 16'd6);
    // R3 halted count does not move
    wr(3'd0, 16'h0001); rd(3'd0, d); chk("R4 kick halted", d, 16'd6);
    ticks(5); rd(3'd0, d); chk("R3 halt", d, 16'd6);
    // R4 kick with wrong value ignored
    wr(3'd4, 16'h0001); ticks(2); rd(3'd0, d); chk("R5 two ticks", d, 16'd4);
    wr(3'd0, 16'h0002); rd(3'd0, d); chk("R4 ignored", d, 16'd4);
    wr(3'd0, 16'h0101); rd(3'd0, d); chk("R4 ignored hi", d, 16'd4);
    wr(3'd0, 16'h0001); rd(3'd0, d); chk("R4 kick", d, 16'd6);
    // sweep over initial values
    for (int v = 4; v <= 12; v++) begin
      wr(3'd4, 16'h0801);
      wr(3'd2, 16'h0008); wr(3'd3, 16'h0006);
      wr(3'd1, 16'(v)); wr(3'd0, 16'h0001);
      wr(3'd4, 16'h0001);
      for (int k = 1; k <= v; k++) begin
        ticks(1); rd(3'd0, d); chk("R5 decrement", d, 16'(v - k));
      end
      rd(3'd2, d); chk("R6 no early expiry", d, 16'h0000);
      ticks(1);
      rd(3'd2, d); chk("R7 first flag", d, 16'h0008);
      rd(3'd0, d); chk("R6 reload", d, 16'(v));
      wr(3'd2, 16'h0000); rd(3'd2, d); chk("R7 write0 keeps", d, 16'h0008);
      wr(3'd4, 16'(v % 2));
      p0 = pulses;
      ticks(v + 1);
      rd(3'd3, d); chk("R8 second flag", d, 16'h0002);
      rd(3'd2, d); chk("R8 first still set", d, 16'h0008);
      if (v % 2 == 1) chk("R9 suppressed", 16'(pulses - p0), 16'd0);
      else            chk("R8 pulse", 16'(pulses - p0), 16'd1);
      ticks(v + 1);
      chk("R11 no repeat", 16'(pulses - p0), 16'((v % 2 == 1) ? 0 : 1));
    end
    // R12 restart of the sequence
    wr(3'd4, 16'h0801);
    wr(3'd2, 16'h0008); wr(3'd3, 16'h0002);
    wr(3'd1, 16'd5); wr(3'd0, 16'h0001); wr(3'd4, 16'h0000);
    p0 = pulses;
    ticks(6); rd(3'd2, d); chk("R12 first", d, 16'h0008);
    wr(3'd2, 16'h0008); rd(3'd2, d); chk("R7 clear", d, 16'h0000);
    ticks(6); rd(3'd2, d); chk("R12 first again", d, 16'h0008);
    rd(3'd3, d); chk("R12 no second", d, 16'h0000);
    chk("R12 no pulse", 16'(pulses - p0), 16'd0);
    ticks(6); rd(3'd3, d); chk("R8 second after restart", d, 16'h0002);
    chk("R11 single pulse", 16'(pulses - p0), 16'd1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule